// File: doc/BRIEF.md
# Dual-Target Interrupt Bank

This block is one bank of a level-sensitive interrupt controller with 32 sources. Each source is the OR of a hardware line and a bit in a software-forced register. The bank serves two targets, a main CPU and a coprocessor. Each target has its own enable mask and its own class mask. The class mask sends each enabled source either to the target's normal interrupt output or to its fast interrupt output. Each of the four outputs is the OR of every source routed to it.

Software uses a small 32-bit register bus. The enable and forced registers can be written directly. They can also be changed bit by bit, without a read-modify-write, through write-one-to-set and write-one-to-clear aliases. Forcing a bit re-triggers a line. Clearing a forced bit acknowledges the line. A read-only view shows the CPU sources that are currently routed to the CPU fast output.

Priority, vectoring and any cascading into a larger distributor sit outside this bank.

Top module: `intc_bank`

## Requirements
- R1: After reset is released, every enable, class and forced register reads zero, all four interrupt outputs are low, and `rsp_rdata_o` is zero.
- R2: The active vector is (hardware lines OR forced register). The hardware lines are level sensitive and pass through a two-flop synchronizer. A line change sampled at clock edge k therefore reaches the outputs after edge k+1, and not earlier.
- R3: `cpu_fiq_o` is high when some source is active, set in the CPU enable register (0x20) and has CPU class bit (0x2C) = 1. `cpu_irq_o` is high when some source is active, enabled and has class bit = 0.
- R4: `cop_fiq_o` and `cop_irq_o` follow the rule of R3, using the coprocessor enable (0x30) and class (0x3C) registers. They are independent of the CPU registers.
- R5: A write to a set alias ORs the written data into its base register. Zero bits in the data leave the register unchanged. The aliases are forced set 0x18, CPU enable set 0x24 and coprocessor enable set 0x34.
- R6: A write to a clear alias clears every bit that is 1 in the data. The aliases are forced clear 0x1C, CPU enable clear 0x28 and coprocessor enable clear 0x38. An all-ones write clears the whole register in one write.
- R7: A write to a base register replaces its whole contents. The base registers are forced 0x14, CPU enable 0x20, CPU class 0x2C, coprocessor enable 0x30 and coprocessor class 0x3C.
- R8: Read data appears on `rsp_rdata_o` in the cycle after a read request and is zero in every other cycle. A read of a set or clear alias returns its base register. A read of 0x08 returns active & CPU enable & CPU class.
- R9: Writes to 0x08 and to any other offset not listed in R5 to R7 are ignored. Reads from unlisted offsets return zero. This includes unaligned offsets.
- R10: Forcing a bit raises the interrupt that its routing selects while the hardware line is low. Clearing the forced bit drops that interrupt again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | N_SRC | Raw level-sensitive hardware interrupt lines |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | N_SRC | Write data |
| rsp_rdata_o | output | N_SRC | Read data, one cycle after a read request |
| cpu_irq_o | output | 1 | CPU normal interrupt |
| cpu_fiq_o | output | 1 | CPU fast interrupt |
| cop_irq_o | output | 1 | Coprocessor normal interrupt |
| cop_fiq_o | output | 1 | Coprocessor fast interrupt |

## Verification
The routing is driven once by a hardware line and once by a forced bit, so the two terms of the active OR are each shown to reach the outputs. A hardware line is sampled one cycle and two cycles after it changes, which separates a two-flop synchronizer from a shorter or longer one. Mixed class patterns, such as upper half fast and lower half normal, and a source that is enabled only for the coprocessor check that class and enable are taken bit by bit and per target. Alias writes whose data mixes ones and zeros, followed by all-ones clears, separate set, clear and replace semantics. Writes to the read-only view and to unmapped or unaligned offsets, each followed by a read-back, show that these writes are ignored.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned OFS_W = 8;
  typedef logic [OFS_W-1:0] ofs_t;

  localparam ofs_t OFS_FIQ_VIEW = 8'h08;
  localparam ofs_t OFS_FRC      = 8'h14;
  localparam ofs_t OFS_FRC_SET  = 8'h18;
  localparam ofs_t OFS_FRC_CLR  = 8'h1C;
  localparam ofs_t OFS_CPU_EN   = 8'h20;
  localparam ofs_t OFS_CPU_SET  = 8'h24;
  localparam ofs_t OFS_CPU_CLR  = 8'h28;
  localparam ofs_t OFS_CPU_CLS  = 8'h2C;
  localparam ofs_t OFS_COP_EN   = 8'h30;
  localparam ofs_t OFS_COP_SET  = 8'h34;
  localparam ofs_t OFS_COP_CLR  = 8'h38;
  localparam ofs_t OFS_COP_CLS  = 8'h3C;

  localparam int unsigned NUM_TGT = 2;
  localparam int unsigned TGT_CPU = 0;
  localparam int unsigned TGT_COP = 1;

  function automatic logic is_readable(ofs_t a);
    case (a)
      OFS_FIQ_VIEW, OFS_FRC, OFS_FRC_SET, OFS_FRC_CLR,
      OFS_CPU_EN, OFS_CPU_SET, OFS_CPU_CLR, OFS_CPU_CLS,
      OFS_COP_EN, OFS_COP_SET, OFS_COP_CLR, OFS_COP_CLS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_writable(ofs_t a);
    return is_readable(a) && (a != OFS_FIQ_VIEW);
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  ofs_t             req_addr_i,
  input  logic [N_SRC-1:0] req_wdata_i,
  output logic [N_SRC-1:0] rsp_rdata_o,
  input  logic [N_SRC-1:0] active_i,
  output logic [N_SRC-1:0] frc_o,
  output logic [N_SRC-1:0] cpu_en_o,
  output logic [N_SRC-1:0] cpu_cls_o,
  output logic [N_SRC-1:0] cop_en_o,
  output logic [N_SRC-1:0] cop_cls_o
);
  logic [N_SRC-1:0] frc_q, cpu_en_q, cpu_cls_q, cop_en_q, cop_cls_q;
  logic [N_SRC-1:0] rdata_q, rmux;
  logic             wr, rd;

  assign wr = req_valid_i &  req_write_i;
  assign rd = req_valid_i & ~req_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frc_q     <= '0;
      cpu_en_q  <= '0;
      cpu_cls_q <= '0;
      cop_en_q  <= '0;
      cop_cls_q <= '0;
    end else if (wr) begin
      case (req_addr_i)
        OFS_FRC:     frc_q     <= req_wdata_i;
        OFS_FRC_SET: frc_q     <= frc_q | req_wdata_i;
        OFS_FRC_CLR: frc_q     <= frc_q & ~req_wdata_i;
        OFS_CPU_EN:  cpu_en_q  <= req_wdata_i;
        OFS_CPU_SET: cpu_en_q  <= cpu_en_q | req_wdata_i;
        OFS_CPU_CLR: cpu_en_q  <= cpu_en_q & ~req_wdata_i;
        OFS_CPU_CLS: cpu_cls_q <= req_wdata_i;
        OFS_COP_EN:  cop_en_q  <= req_wdata_i;
        OFS_COP_SET: cop_en_q  <= cop_en_q | req_wdata_i;
        OFS_COP_CLR: cop_en_q  <= cop_en_q & ~req_wdata_i;
        OFS_COP_CLS: cop_cls_q <= req_wdata_i;
        default: ;
      endcase
    end
  end

  // alias offsets read back their base register
  always_comb begin
    case (req_addr_i)
      OFS_FIQ_VIEW:                     rmux = active_i & cpu_en_q & cpu_cls_q;
      OFS_FRC, OFS_FRC_SET, OFS_FRC_CLR: rmux = frc_q;
      OFS_CPU_EN, OFS_CPU_SET, OFS_CPU_CLR: rmux = cpu_en_q;
      OFS_CPU_CLS:                      rmux = cpu_cls_q;
      OFS_COP_EN, OFS_COP_SET, OFS_COP_CLR: rmux = cop_en_q;
      OFS_COP_CLS:                      rmux = cop_cls_q;
      default:                          rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rmux : '0;
  end

  assign rsp_rdata_o = rdata_q;
  assign frc_o       = frc_q;
  assign cpu_en_o    = cpu_en_q;
  assign cpu_cls_o   = cpu_cls_q;
  assign cop_en_o    = cop_en_q;
  assign cop_cls_o   = cop_cls_q;
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int unsigned N_SRC = 32
) (
  input  logic [N_SRC-1:0] active_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] cls_i,
  output logic             irq_o,
  output logic             fiq_o
);
  logic [N_SRC-1:0] gated;

  assign gated = active_i & en_i;
  assign irq_o = |(gated & ~cls_i);
  assign fiq_o = |(gated &  cls_i);
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_lines_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [OFS_W-1:0] req_addr_i,
  input  logic [N_SRC-1:0] req_wdata_i,
  output logic [N_SRC-1:0] rsp_rdata_o,
  output logic             cpu_irq_o,
  output logic             cpu_fiq_o,
  output logic             cop_irq_o,
  output logic             cop_fiq_o
);
  logic [N_SRC-1:0] lines_sync, active_w, frc_w;
  logic [N_SRC-1:0] cpu_en_w, cpu_cls_w, cop_en_w, cop_cls_w;
  logic [NUM_TGT-1:0][N_SRC-1:0] en_a, cls_a;
  logic [NUM_TGT-1:0] irq_a, fiq_a;

  intc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_lines_i),
    .q_o   (lines_sync)
  );

  assign active_w = lines_sync | frc_w;

  intc_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .rsp_rdata_o(rsp_rdata_o),
    .active_i   (active_w),
    .frc_o      (frc_w),
    .cpu_en_o   (cpu_en_w),
    .cpu_cls_o  (cpu_cls_w),
    .cop_en_o   (cop_en_w),
    .cop_cls_o  (cop_cls_w)
  );

  assign en_a[TGT_CPU]  = cpu_en_w;
  assign en_a[TGT_COP]  = cop_en_w;
  assign cls_a[TGT_CPU] = cpu_cls_w;
  assign cls_a[TGT_COP] = cop_cls_w;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    intc_route #(.N_SRC(N_SRC)) u_route (
      .active_i(active_w),
      .en_i    (en_a[t]),
      .cls_i   (cls_a[t]),
      .irq_o   (irq_a[t]),
      .fiq_o   (fiq_a[t])
    );
  end

  assign cpu_irq_o = irq_a[TGT_CPU];
  assign cpu_fiq_o = fiq_a[TGT_CPU];
  assign cop_irq_o = irq_a[TGT_COP];
  assign cop_fiq_o = fiq_a[TGT_COP];
endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [OFS_W-1:0] req_addr_i,
  input logic [N_SRC-1:0] req_wdata_i,
  input logic [N_SRC-1:0] rsp_rdata_o,
  input logic             cpu_irq_o,
  input logic [N_SRC-1:0] frc_w,
  input logic [N_SRC-1:0] cpu_en_w,
  input logic [N_SRC-1:0] cpu_cls_w,
  input logic [N_SRC-1:0] cop_en_w,
  input logic [N_SRC-1:0] cop_cls_w
);
  logic wr, rd;
  assign wr = req_valid_i &  req_write_i;
  assign rd = req_valid_i & ~req_write_i;

  a_r5_cpu_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && req_addr_i == OFS_CPU_SET |=> cpu_en_w == $past(cpu_en_w | req_wdata_i));

  a_r5_cop_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && req_addr_i == OFS_COP_SET |=> cop_en_w == $past(cop_en_w | req_wdata_i));

  a_r6_frc_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && req_addr_i == OFS_FRC_CLR |=> frc_w == $past(frc_w & ~req_wdata_i));

  a_r8_alias_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && req_addr_i == OFS_CPU_CLR |=> rsp_rdata_o == $past(cpu_en_w));

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> rsp_rdata_o == '0);

  a_r9_undef_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !is_writable(req_addr_i) |=>
      $stable(frc_w) && $stable(cpu_en_w) && $stable(cpu_cls_w) &&
      $stable(cop_en_w) && $stable(cop_cls_w));

  a_r9_undef_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && !is_readable(req_addr_i) |=> rsp_rdata_o == '0);

  a_r10_force_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && req_addr_i == OFS_FRC_SET && |(req_wdata_i & cpu_en_w & ~cpu_cls_w) |=> cpu_irq_o);
endmodule

bind intc_bank intc_bank_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .rsp_rdata_o(rsp_rdata_o),
  .cpu_irq_o  (cpu_irq_o),
  .frc_w      (frc_w),
  .cpu_en_w   (cpu_en_w),
  .cpu_cls_w  (cpu_cls_w),
  .cop_en_w   (cop_en_w),
  .cop_cls_w  (cop_cls_w)
);

// File: tb/sim_intc_bank.sv
`timescale 1ns/1ps
module sim_intc_bank;
  localparam int unsigned N = 32;
  localparam logic [7:0] A_VIEW = 8'h08, A_FRC = 8'h14, A_FSET = 8'h18, A_FCLR = 8'h1C;
  localparam logic [7:0] A_CEN = 8'h20, A_CSET = 8'h24, A_CCLR = 8'h28, A_CCLS = 8'h2C;
  localparam logic [7:0] A_PEN = 8'h30, A_PSET = 8'h34, A_PCLR = 8'h38, A_PCLS = 8'h3C;
  localparam logic [N-1:0] ONES = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic vld = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [N-1:0] wdata = '0, rdata;
  logic cpu_irq, cpu_fiq, cop_irq, cop_fiq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  intc_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .req_valid_i(vld), .req_write_i(we), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_rdata_o(rdata), .cpu_irq_o(cpu_irq), .cpu_fiq_o(cpu_fiq),
    .cop_irq_o(cop_irq), .cop_fiq_o(cop_fiq)
  );

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic outs(string tag, logic [3:0] exp);
    chk(tag, {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, {28'h0, exp});
  endtask

  task automatic wr(logic [7:0] a, logic [N-1:0] d);
    @(negedge clk); vld = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); vld = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk); vld = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); vld = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [N-1:0] exp);
    logic [N-1:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    outs("R1 outputs", 4'b0000);
    chk("R1 rdata", rdata, '0);
    rd_chk("R1 cpu_en", A_CEN, '0);
    rd_chk("R1 cpu_cls", A_CCLS, '0);
    rd_chk("R1 cop_en", A_PEN, '0);
    rd_chk("R1 cop_cls", A_PCLS, '0);
    rd_chk("R1 forced", A_FRC, '0);
  endtask

  task automatic t_alias();
    wr(A_CSET, 32'h0000_00F0);
    wr(A_CSET, 32'h0000_000F);
    rd_chk("R5 cpu set merges", A_CEN, 32'h0000_00FF);
    rd_chk("R8 set alias reads base", A_CSET, 32'h0000_00FF);
    wr(A_CCLR, 32'h0000_0033);
    rd_chk("R6 cpu clear partial", A_CEN, 32'h0000_00CC);
    rd_chk("R8 clear alias reads base", A_CCLR, 32'h0000_00CC);
    wr(A_CCLR, ONES);
    rd_chk("R6 cpu clear all-ones", A_CEN, '0);
    wr(A_PSET, 32'h8000_0001);
    rd_chk("R5 cop set", A_PEN, 32'h8000_0001);
    wr(A_PCLR, ONES);
    rd_chk("R6 cop clear all-ones", A_PEN, '0);
  endtask

  task automatic t_direct();
    wr(A_CEN, 32'hA5A5_0000);
    rd_chk("R7 cpu_en replace", A_CEN, 32'hA5A5_0000);
    wr(A_CEN, 32'h0000_0001);
    rd_chk("R7 cpu_en overwrite", A_CEN, 32'h0000_0001);
    wr(A_PCLS, 32'h1234_5678);
    rd_chk("R7 cop_cls replace", A_PCLS, 32'h1234_5678);
    wr(A_PCLS, '0);
    wr(A_CEN, '0);
  endtask

  task automatic t_hw();
    wr(A_CSET, 32'h0000_0004);
    @(negedge clk); lines = 32'h0000_0004;
    @(negedge clk);
    outs("R2 not after one edge", 4'b0000);
    @(negedge clk);
    outs("R2 after two edges, R3 irq class0", 4'b1000);
    wr(A_CCLS, 32'h0000_0004);
    outs("R3 class1 to fiq", 4'b0100);
    rd_chk("R8 fiq view", A_VIEW, 32'h0000_0004);
    wr(A_CCLR, 32'h0000_0004);
    outs("R3 disabled source masked", 4'b0000);
    rd_chk("R8 fiq view masked", A_VIEW, '0);
    @(negedge clk); lines = '0;
    wr(A_CCLS, '0);
  endtask

  task automatic t_cop();
    wr(A_PSET, 32'h0000_0020);
    wr(A_FSET, 32'h0000_0020);
    outs("R10 forced raises cop irq, R4 cpu unaffected", 4'b0010);
    wr(A_PCLS, 32'h0000_0020);
    outs("R4 cop class1 to fiq", 4'b0001);
    rd_chk("R8 forced via clear alias", A_FCLR, 32'h0000_0020);
    wr(A_CCLS, 32'h0000_0020);
    wr(A_CSET, 32'h0000_0020);
    outs("R4 cpu fiq with cop fiq", 4'b0101);
    wr(A_CCLR, ONES);
    wr(A_FCLR, 32'h0000_0020);
    outs("R10 clear forced drops cop fiq", 4'b0000);
    wr(A_PCLR, ONES);
    wr(A_PCLS, '0);
    wr(A_CCLS, '0);
  endtask

  task automatic t_undef();
    wr(A_CEN, 32'h0000_0F00);
    wr(A_VIEW, ONES);
    wr(8'h40, ONES);
    wr(8'h21, ONES);
    wr(8'h00, ONES);
    rd_chk("R9 undef writes ignored cpu_en", A_CEN, 32'h0000_0F00);
    rd_chk("R9 undef writes ignored forced", A_FRC, '0);
    rd_chk("R9 undef writes ignored cop_en", A_PEN, '0);
    outs("R9 outputs unchanged", 4'b0000);
    rd_chk("R9 read 0x40 zero", 8'h40, '0);
    rd_chk("R9 read unaligned zero", 8'h25, '0);
    wr(A_CCLR, ONES);
  endtask

  task automatic t_mix();
    wr(A_FRC, ONES);
    wr(A_CSET, ONES);
    wr(A_CCLS, 32'hFFFF_0000);
    outs("R3 mixed classes both outputs", 4'b1100);
    rd_chk("R8 fiq view upper half", A_VIEW, 32'hFFFF_0000);
    wr(A_FRC, 32'h0000_8000);
    outs("R7 forced replaced, irq only", 4'b1000);
    wr(A_FRC, 32'h0001_0000);
    outs("R3 upper bit fiq only", 4'b0100);
    wr(A_FCLR, ONES);
    outs("R6 forced all-ones clear", 4'b0000);
    rd_chk("R6 forced empty", A_FRC, '0);
    @(negedge clk);
    chk("R8 rdata idle zero", rdata, '0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_direct();
    t_hw();
    t_cop();
    t_undef();
    t_mix();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule